// File: doc/BRIEF.md
# Exact-Count Pulse Burst Generator

This block plays out bursts of pulses. Each burst is described by a segment: a pulse count, a phase increment and a one-shot flag. A host writes segments through a valid/ready port into a small queue. The block then plays them back to back from a phase-accumulator oscillator. Each clock the accumulator adds the increment, and the top bit of the accumulator drives the output. The output frequency is therefore increment × f_clk / 2^32. With an 80 MHz clock, a frequency such as 300 kHz can only be approximated.

Each segment ends cleanly. The pulse count drops on every low-to-high transition of the output. Once the count is exhausted, the segment closes on the falling edge of the last pulse. At that point the accumulator is cleared to zero, so the output rests low. The next queued segment then starts from phase zero, and it needs no help from the host. The host only starts a run, then checks `done` or `busy` whenever it finds convenient.

Some segments are rejected and skipped. A segment with a count of zero is dropped silently. A segment with a nonzero count and a zero increment raises a one-cycle error strobe and is dropped.

Top module: `pulse_burst_gen`

## Requirements
- R1: Out of reset, `pulse_out` is 0, `busy` is 0, `done` is 1, `seg_err` is 0 and `seg_ready` is 1.
- R2: A normal segment (`seg_oneshot`=0) with count N ≥ 1 emits exactly N rising edges on `pulse_out`. This holds for counts wider than 16 bits.
- R3: For an increment of 2^k, every pulse of a normal segment is high for 2^(31-k) cycles. Within a segment the output is also low for 2^(31-k) cycles between pulses.
- R4: Whenever `busy` is 0, `pulse_out` is 0. A finished segment leaves the output low.
- R5: A segment starts one cycle after the previous segment closes, from phase zero. Each skipped segment in between adds one cycle. For a normal segment of increment 2^k, the output stays low for 2^(31-k)+1 cycles after the preceding pulse. Skipped segments add to this.
- R6: A one-shot segment (`seg_oneshot`=1) emits exactly one pulse, whatever its nonzero count. The accumulator is preset to 2^31 and advances only while bit 31 is set. The pulse therefore goes high one cycle after the previous segment closes and lasts 2^(31-k) cycles.
- R7: A segment with count 0 produces no pulse and no error strobe.
- R8: A segment with a nonzero count and an increment of 0 produces no pulse and a single cycle of `seg_err`=1.
- R9: The queue holds 4 segments. `seg_ready` is 0 while 4 segments are waiting, and a segment is accepted only when `seg_valid` and `seg_ready` are both 1 at a clock edge.
- R10: `busy` is 1 from the cycle after a segment is accepted until the queue is empty and no segment is playing. `done` goes to 0 with `busy` and returns to 1 one cycle after `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_valid | input | 1 | Segment offered on the load port |
| seg_ready | output | 1 | Queue has room |
| seg_count | input | 32 | Pulses in the segment |
| seg_incr | input | 32 | Phase increment per clock |
| seg_oneshot | input | 1 | Single self-quenching pulse |
| pulse_out | output | 1 | Pulse train (accumulator bit 31) |
| busy | output | 1 | Segment queued or playing |
| done | output | 1 | Queue drained and output idle |
| seg_err | output | 1 | One-cycle strobe for a zero-increment segment |

## Verification
The assertions assume the host holds a segment's fields stable while `seg_valid` waits for `seg_ready`. The bench drives the load port only on the falling edge and releases it after an accepted edge, so this holds. The pulse-width and gap checks rely on power-of-two increments, because only those make the accumulator wrap exactly to zero. Every increment in the stimulus is therefore 2^k. The queue-full check keeps one long segment playing while four more are pushed back to back, so the queue fills before anything drains.

// File: rtl/pbg_pkg.sv
package pbg_pkg;
  localparam int ACC_W = 32;
  localparam int CNT_W = 32;

  typedef struct packed {
    logic             oneshot;
    logic [ACC_W-1:0] incr;
    logic [CNT_W-1:0] count;
  } seg_t;

  localparam int SEG_W = $bits(seg_t);

  // Next accumulator value; one-shot mode advances only while the top bit is set.
  function automatic logic [ACC_W-1:0] phase_step(input logic [ACC_W-1:0] acc,
                                                  input logic [ACC_W-1:0] incr,
                                                  input logic             oneshot);
    if (oneshot && !acc[ACC_W-1]) return acc;
    return acc + incr;
  endfunction

  // Starting phase for a freshly loaded segment.
  function automatic logic [ACC_W-1:0] start_phase(input logic oneshot);
    return oneshot ? {1'b1, {(ACC_W-1){1'b0}}} : '0;
  endfunction
endpackage

// File: rtl/pbg_fifo.sv
module pbg_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  // R9: a full queue stays full until something is taken out
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> empty);
endmodule

// File: rtl/pbg_engine.sv
module pbg_engine
  import pbg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic q_empty,
  input  seg_t q_head,
  output logic q_pop,
  output logic running,
  output logic pulse,
  output logic seg_err
);
  typedef enum logic {ST_IDLE, ST_RUN} st_t;

  st_t              st;
  logic [ACC_W-1:0] acc, acc_nxt, incr;
  logic [CNT_W-1:0] remain;
  logic             oneshot;

  // named internal events
  logic rise_ev, fall_ev, seg_end, take_seg, zero_cnt, zero_inc;

  always_comb begin
    acc_nxt  = phase_step(acc, incr, oneshot);
    rise_ev  = (st == ST_RUN) && !acc[ACC_W-1] &&  acc_nxt[ACC_W-1];
    fall_ev  = (st == ST_RUN) &&  acc[ACC_W-1] && !acc_nxt[ACC_W-1];
    seg_end  = fall_ev && (oneshot || remain == '0);
    q_pop    = (st == ST_IDLE) && !q_empty;
    zero_cnt = (q_head.count == '0);
    zero_inc = (q_head.incr == '0);
    take_seg = q_pop && !zero_cnt && !zero_inc;
  end

  assign running = (st == ST_RUN);
  assign pulse   = acc[ACC_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      acc     <= '0;
      incr    <= '0;
      remain  <= '0;
      oneshot <= 1'b0;
      seg_err <= 1'b0;
    end else begin
      seg_err <= q_pop && !zero_cnt && zero_inc;
      case (st)
        ST_IDLE: begin
          if (take_seg) begin
            st      <= ST_RUN;
            incr    <= q_head.incr;
            remain  <= q_head.count;
            oneshot <= q_head.oneshot;
            acc     <= start_phase(q_head.oneshot);
          end
        end
        default: begin
          if (rise_ev) remain <= remain - 1'b1;
          if (seg_end) begin
            st  <= ST_IDLE;
            acc <= '0;
          end else begin
            acc <= acc_nxt;
          end
        end
      endcase
    end
  end

  // R2: once the count is used up, no further pulse may start
  p_no_extra_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !oneshot && remain == '0) |-> !rise_ev);
  // R6: a one-shot segment never sees a low-to-high crossing
  p_oneshot_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && oneshot) |-> !rise_ev);
  // R8: an error strobe follows a pop made while idle
  p_err_from_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop && !zero_cnt && zero_inc |=> seg_err && !running);
  // R5: a closing segment leaves the accumulator at zero
  p_clean_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seg_end |=> (acc == '0) && !running);
endmodule

// File: rtl/pulse_burst_gen.sv
module pulse_burst_gen
  import pbg_pkg::*;
#(
  parameter int QDEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seg_valid,
  output logic        seg_ready,
  input  logic [31:0] seg_count,
  input  logic [31:0] seg_incr,
  input  logic        seg_oneshot,
  output logic        pulse_out,
  output logic        busy,
  output logic        done,
  output logic        seg_err
);
  seg_t in_seg, head;
  logic q_empty, q_full, q_pop, running, accept;

  assign in_seg    = '{oneshot: seg_oneshot, incr: seg_incr, count: seg_count};
  assign seg_ready = !q_full;
  assign accept    = seg_valid && seg_ready;
  assign busy      = !q_empty || running;

  pbg_fifo #(.DEPTH(QDEPTH), .W(SEG_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (accept),
    .wdata (in_seg),
    .pop   (q_pop),
    .rdata (head),
    .empty (q_empty),
    .full  (q_full)
  );

  pbg_engine u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .q_empty (q_empty),
    .q_head  (head),
    .q_pop   (q_pop),
    .running (running),
    .pulse   (pulse_out),
    .seg_err (seg_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      done <= 1'b1;
    else if (accept) done <= 1'b0;
    else if (!busy)  done <= 1'b1;
  end

  // R4: the output rests low whenever nothing is queued or playing
  p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pulse_out);
  // R10: done and busy are never high together
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R10: an accepted segment makes the block busy on the next cycle
  p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && !done);
endmodule

// File: tb/pulse_burst_gen_tb.sv
module pulse_burst_gen_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_valid = 1'b0;
  logic [31:0] seg_count = '0;
  logic [31:0] seg_incr = '0;
  logic        seg_oneshot = 1'b0;
  logic        seg_ready, pulse_out, busy, done, seg_err;

  int checks = 0;
  int fails  = 0;
  int err_seen = 0;
  int rises_seen = 0;
  bit stop_mon = 1'b0;

  // scoreboard: one entry per expected pulse
  int q_width[$];
  int q_gap[$];   // expected low cycles before the pulse, -1 = unchecked
  string q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_burst_gen u_dut (
    .clk(clk), .rst_n(rst_n), .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_count(seg_count), .seg_incr(seg_incr), .seg_oneshot(seg_oneshot),
    .pulse_out(pulse_out), .busy(busy), .done(done), .seg_err(seg_err)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // half-width for an increment of 2**k
  function automatic int half_of(input int k);
    return 1 << (31 - k);
  endfunction

  // queue the expected pulses of one segment
  task automatic expect_seg(input int n, input int k, input int first_gap, input string tag);
    for (int i = 0; i < n; i++) begin
      q_width.push_back(half_of(k));
      q_gap.push_back(i == 0 ? first_gap : half_of(k));
      q_tag.push_back(tag);
    end
  endtask

  task automatic push_seg(input int unsigned cnt, input int unsigned inc, input bit os);
    @(negedge clk);
    seg_valid   = 1'b1;
    seg_count   = cnt;
    seg_incr    = inc;
    seg_oneshot = os;
    while (!seg_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    seg_valid = 1'b0;
  endtask

  // monitor: measures every pulse and compares with the scoreboard
  initial begin
    int hi = 0;
    int lo = 0;
    bit prev = 1'b0;
    forever begin
      @(negedge clk);
      if (stop_mon) break;
      if (!rst_n) begin
        hi = 0; lo = 0; prev = 1'b0;
        continue;
      end
      if (seg_err) err_seen++;
      if (pulse_out && !prev) begin
        rises_seen++;
        if (q_width.size() == 0) begin
          check(1'b0, "R2 extra pulse", rises_seen, 0);
        end else if (q_gap[0] >= 0) begin
          check(lo == q_gap[0], {q_tag[0], " low gap"}, lo, q_gap[0]);
        end
        hi = 1;
      end else if (pulse_out) begin
        hi++;
      end else if (prev) begin
        if (q_width.size() != 0) begin
          check(hi == q_width[0], {q_tag[0], " high width"}, hi, q_width[0]);
          void'(q_width.pop_front());
          void'(q_gap.pop_front());
          void'(q_tag.pop_front());
        end
        lo = 1;
      end else begin
        lo++;
      end
      prev = pulse_out;
    end
  end

  initial begin
    bit fin = 1'b0;
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(pulse_out == 1'b0, "R1 pulse_out", pulse_out, 0);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(done == 1'b1, "R1 done", done, 1);
        check(seg_err == 1'b0, "R1 seg_err", seg_err, 0);
        check(seg_ready == 1'b1, "R1 seg_ready", seg_ready, 1);

        // A: 5 pulses at incr 2^28 (R2, R3)
        expect_seg(5, 28, -1, "R3 segA");
        push_seg(5, 32'h1000_0000, 1'b0);
        check(busy == 1'b1, "R10 busy after accept", busy, 1);
        check(done == 1'b0, "R10 done after accept", done, 0);
        // B: 3 pulses at 2^29, gap h+1 (R5)
        expect_seg(3, 29, half_of(29) + 1, "R5 segB");
        push_seg(3, 32'h2000_0000, 1'b0);
        // C: zero count skipped (R7)
        push_seg(0, 32'h2000_0000, 1'b0);
        // D: zero increment flagged (R8)
        push_seg(2, 32'h0, 1'b0);
        // E: one-shot, count 7 -> one pulse; gap = 1 + two skips (R6)
        expect_seg(1, 27, 3, "R6 segE");
        push_seg(7, 32'h0800_0000, 1'b1);
        // queue holds B..E while A plays (R9)
        check(seg_ready == 1'b0, "R9 ready low when full", seg_ready, 0);
        // F: 234 pulses at 2^30 (R2, R3)
        expect_seg(234, 30, half_of(30) + 1, "R2 segF");
        push_seg(234, 32'h4000_0000, 1'b0);
        // G: count wider than 16 bits at 2^31 (R2)
        expect_seg(66000, 31, half_of(31) + 1, "R2 segG");
        push_seg(66000, 32'h8000_0000, 1'b0);

        while (!done) @(negedge clk);
        repeat (20) @(negedge clk);
        check(busy == 1'b0, "R10 busy at end", busy, 0);
        check(done == 1'b1, "R10 done at end", done, 1);
        check(pulse_out == 1'b0, "R4 idle low", pulse_out, 0);
        check(q_width.size() == 0, "R2 missing pulses", q_width.size(), 0);
        check(rises_seen == 5 + 3 + 1 + 234 + 66000, "R2 total rises",
              rises_seen, 5 + 3 + 1 + 234 + 66000);
        check(err_seen == 1, "R8 error strobes (R7 adds none)", err_seen, 1);
        fin = 1'b1;
      end
      begin
        repeat (WATCHDOG) @(posedge clk);
      end
    join_any
    disable fork;
    stop_mon = 1'b1;
    if (!fin) check(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule